// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block produces the processor reset of a chip from two digital supply indications and from the activity on a chip-select line. A supply-good condition exists when both the "supply above trip level" flag and the power-valid flag are high. While that condition is missing, reset is driven active. Once it returns, reset is released only after the condition has held, with no break, for a programmed number of clock cycles. The same hold interval applies after power-up and after a brownout, and a single counter serves both cases.

A watchdog watches the chip-select line. Only a falling edge of chip-select, seen through a synchronizer, restarts it. If the line sits high or sits low for the selected timeout while the watchdog is enabled and reset is released, the watchdog forces a reset. That reset also lasts one hold interval. The watchdog counter stays cleared while reset is active or the watchdog is disabled. A 2-bit select scales the base timeout by 1, 2, 4 or 8. A build parameter chooses whether the reset output is active-low or active-high. All time intervals are clock-cycle counts set through parameters.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst_n` is low, and afterwards until the supply-good condition first holds, the reset output is active.
- R2: Reset is released at the HOLD_CYC-th consecutive clock edge at which `supply_ok` and `pwr_valid` are both high.
- R3: A low level on either `supply_ok` or `pwr_valid` drives reset active at the next clock edge.
- R4: A loss of supply-good during the hold interval restarts the hold count from zero.
- R5: With `wdog_en` high and `cs_n` held high, reset goes active WDOG_BASE << `wdog_sel` clock edges after release or after the enable rises.
- R6: With `cs_n` held low, reset goes active SYNC_STAGES + 1 + timeout edges after the edge at which `cs_n` fell, and it fires again one timeout after each release while `cs_n` stays low.
- R7: Each falling edge of `cs_n` restarts the watchdog count, so falling edges spaced closer than the timeout keep reset released.
- R8: A watchdog reset lasts exactly HOLD_CYC cycles. The watchdog count then starts again from zero, so the next expiry comes one full timeout after the release.
- R9: With `wdog_en` low, the watchdog never drives reset, however long `cs_n` stays unchanged.
- R10: `wdog_sel` value s (0 to 3) selects a timeout of WDOG_BASE * 2^s cycles. For example, s = 2 gives four times the base.
- R11: With ACTIVE_LOW = 1, an active reset is `sys_rst` = 0. With ACTIVE_LOW = 0, an active reset is `sys_rst` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above trip level, synchronous to clk |
| pwr_valid | input | 1 | Supply high enough for valid logic levels |
| cs_n | input | 1 | Chip-select line watched by the watchdog (asynchronous) |
| wdog_en | input | 1 | Watchdog enable |
| wdog_sel | input | 2 | Timeout select, scales WDOG_BASE by 2^wdog_sel |
| sys_rst | output | 1 | Reset output, polarity set by ACTIVE_LOW |

## Verification
The bench targets several corner cases. It drops supply-good partway through a hold interval: a design that only paused its counter would release early. It holds chip-select low after a final falling edge, which catches a watchdog that treats a low level as activity or that miscounts the synchronizer delay. It lets the watchdog fire twice in a row, so a counter that is not cleared by the hold would fire a second time too early. It also leaves chip-select idle with the watchdog off, and checks every expected output level on both polarity variants at once, so an inverted build option would show up at every check.

// File: rtl/sup_rst_pkg.sv
// Package: shared types and helpers for the supply supervisor reset generator.
// Assumes: select width is fixed at two bits (four timeout scales).
package sup_rst_pkg;

    localparam int WD_SEL_W = 2;

    // Hold controller state: reset held (counting) or released (running).
    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } hold_state_e;

    // Largest watchdog timeout reachable by any select value.
    function automatic int unsigned wd_max_timeout(input int unsigned base);
        return base << ((1 << WD_SEL_W) - 1);
    endfunction

endpackage

// File: rtl/sup_cs_edge.sv
// Module: synchronizes the asynchronous chip-select line and flags its falling edge.
// Assumes: SYNC_STAGES >= 2; cs_n idles high, so the chain resets to ones.
module sup_cs_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_fall
);

    // stage[i] is flop i of the chain; stage[SYNC_STAGES] is the delayed copy for edge detection.
    logic [SYNC_STAGES:0] stage;

    for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop: captures the raw line.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= 1'b1;
                else        stage[g] <= cs_n;
            end
        end else begin : g_next
            // Later flops: move the sample one stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= 1'b1;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    // Falling edge: the delayed copy is still high and the synchronized value is low.
    assign cs_fall = stage[SYNC_STAGES] & ~stage[SYNC_STAGES-1];

endmodule

// File: rtl/sup_wdog.sv
// Module: chip-select activity watchdog with a selectable timeout.
// Assumes: WDOG_BASE >= 2; clr is high whenever reset is active; fire is a level
// that the hold controller turns into a reset, and clr then clears the count.
module sup_wdog
    import sup_rst_pkg::*;
#(
    parameter int unsigned WDOG_BASE = 15_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                clr,
    input  logic                kick,
    input  logic [WD_SEL_W-1:0] sel,
    output logic                fire
);

    localparam int unsigned MAX_T = wd_max_timeout(WDOG_BASE);
    localparam int          CW    = $clog2(MAX_T + 1);

    logic [CW-1:0] wcnt;
    logic [CW-1:0] last;

    // Terminal count for the selected timeout.
    always_comb begin
        last = (CW'(WDOG_BASE) << sel) - CW'(1);
    end

    // Expiry: enabled, reset released, no restart in this cycle, count at terminal value.
    assign fire = en & ~clr & ~kick & (wcnt >= last);

    // Count cycles without a chip-select falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr || kick) begin
            wcnt <= '0;
        end else if (!fire) begin
            wcnt <= wcnt + CW'(1);
        end
    end

endmodule

// File: rtl/sup_hold_ctrl.sv
// Module: shared hold-off timer for power-up, brownout and watchdog resets.
// Assumes: HOLD_CYC >= 2; supply_good is synchronous to clk.
module sup_hold_ctrl
    import sup_rst_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_good,
    input  logic wd_fire,
    output logic rst_act
);

    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    hold_state_e   state;
    logic [CW-1:0] cnt;

    // Hold state and counter: supply loss always wins, a watchdog expiry restarts the hold.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_good) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else begin
            case (state)
                ST_HOLD: begin
                    if (cnt == LAST) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_RUN: begin
                    if (wd_fire) begin
                        state <= ST_HOLD;
                        cnt   <= '0;
                    end
                end
                default: begin
                    state <= ST_HOLD;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Reset is active in every cycle the controller holds.
    assign rst_act = (state == ST_HOLD);

endmodule

// File: rtl/sup_reset_gen.sv
// Module: top of the supply supervisor reset generator.
// Assumes: supply_ok and pwr_valid are already synchronous; cs_n may be asynchronous.
// ACTIVE_LOW chooses the output polarity at build time.
module sup_reset_gen
    import sup_rst_pkg::*;
#(
    parameter bit          ACTIVE_LOW  = 1'b1,
    parameter int unsigned HOLD_CYC    = 20_000_000,
    parameter int unsigned WDOG_BASE   = 15_000_000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                supply_ok,
    input  logic                pwr_valid,
    input  logic                cs_n,
    input  logic                wdog_en,
    input  logic [WD_SEL_W-1:0] wdog_sel,
    output logic                sys_rst
);

    logic supply_good;
    logic cs_fall;
    logic wd_fire;
    logic rst_act;

    // Supply counts as good only when both indications agree.
    assign supply_good = supply_ok & pwr_valid;

    sup_cs_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_cs_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .cs_fall(cs_fall)
    );

    sup_wdog #(
        .WDOG_BASE(WDOG_BASE)
    ) u_wdog (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (wdog_en),
        .clr  (rst_act),
        .kick (cs_fall),
        .sel  (wdog_sel),
        .fire (wd_fire)
    );

    sup_hold_ctrl #(
        .HOLD_CYC(HOLD_CYC)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_good(supply_good),
        .wd_fire    (wd_fire),
        .rst_act    (rst_act)
    );

    // Output polarity chosen at build time.
    if (ACTIVE_LOW) begin : g_out_low
        assign sys_rst = ~rst_act;
    end else begin : g_out_high
        assign sys_rst = rst_act;
    end

endmodule

// File: rtl/sup_reset_gen_chk.sv
// Module: property checker for sup_reset_gen, attached by bind below.
// Assumes: it sees the internal reset level and the watchdog expiry of the top.
module sup_reset_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic pwr_valid,
    input logic wdog_en,
    input logic rst_act,
    input logic wd_fire
);

    // R1: reset is active in the cycle after any reset-sampling edge.
    assert_rst_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> rst_act);

    // R3: a missing supply indication forces reset at the next edge.
    assert_drop_asserts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(supply_ok && pwr_valid) |=> rst_act);

    // R2: a release happens only after an edge with good supply.
    assert_release_needs_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_act) |-> $past(supply_ok && pwr_valid));

    // R8: a new reset under good supply comes from a watchdog expiry.
    assert_rise_from_wdog_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_act) && $past(supply_ok && pwr_valid)) |-> $past(wd_fire));

    // R9: a disabled watchdog never expires in the following cycle.
    assert_no_fire_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wdog_en |=> !wd_fire);

endmodule

bind sup_reset_gen sup_reset_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .pwr_valid(pwr_valid),
    .wdog_en  (wdog_en),
    .rst_act  (rst_act),
    .wd_fire  (wd_fire)
);

// File: tb/sup_reset_gen_tb_top.sv
// Bench: scoreboard of expected reset levels at absolute cycle numbers.
module sup_reset_gen_tb_top;

    localparam int H  = 20;
    localparam int T0 = 16;
    localparam int S  = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       supply_ok;
    logic       pwr_valid;
    logic       cs_n;
    logic       wdog_en;
    logic [1:0] wdog_sel;
    logic       sys_rst_lo;
    logic       sys_rst_hi;

    int cyc    = 0;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        int    cyc;
        bit    act;
        string req;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    sup_reset_gen #(
        .ACTIVE_LOW(1'b1), .HOLD_CYC(H), .WDOG_BASE(T0), .SYNC_STAGES(S)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwr_valid(pwr_valid),
        .cs_n(cs_n), .wdog_en(wdog_en), .wdog_sel(wdog_sel), .sys_rst(sys_rst_lo)
    );

    sup_reset_gen #(
        .ACTIVE_LOW(1'b0), .HOLD_CYC(H), .WDOG_BASE(T0), .SYNC_STAGES(S)
    ) dut_hi (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwr_valid(pwr_valid),
        .cs_n(cs_n), .wdog_en(wdog_en), .wdog_sel(wdog_sel), .sys_rst(sys_rst_hi)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: push the expected internal reset level (1 = active) for a cycle.
    task automatic expect_at(input int c, input bit act, input string req);
        q.push_back('{cyc: c, act: act, req: req});
    endtask

    // Monitor: compares both polarity variants (R11) with every due expectation.
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                checks++;
                if ((~sys_rst_lo) !== q[i].act || sys_rst_hi !== q[i].act) begin
                    errors++;
                    $display("FAIL %s/R11 cycle %0d: low-variant sys_rst=%b high-variant sys_rst=%b, expected active=%0b",
                             q[i].req, cyc, sys_rst_lo, sys_rst_hi, q[i].act);
                end
                q.delete(i);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
        finish_run();
    end

    initial begin
        int p;
        rst_n = 1'b0; supply_ok = 1'b0; pwr_valid = 1'b0;
        cs_n = 1'b1; wdog_en = 1'b0; wdog_sel = 2'd0;
        tick(1);
        expect_at(cyc + 2, 1'b1, "R1");
        tick(4);
        rst_n = 1'b1;
        expect_at(cyc + 5, 1'b1, "R1");
        tick(8);

        // R2: release after H good edges.
        p = cyc; supply_ok = 1'b1; pwr_valid = 1'b1;
        expect_at(p + H - 1, 1'b1, "R2");
        expect_at(p + H, 1'b0, "R2");
        tick(H + 5);

        // R3: supply_ok drop asserts reset at the next edge.
        p = cyc;
        expect_at(p + 1, 1'b0, "R3");
        expect_at(p + 2, 1'b1, "R3");
        tick(1); supply_ok = 1'b0;
        tick(3);

        // R4: a dip during the hold restarts the count.
        p = cyc; supply_ok = 1'b1;
        expect_at(p + H, 1'b1, "R4");
        tick(10); supply_ok = 1'b0;
        tick(1);
        p = cyc; supply_ok = 1'b1;
        expect_at(p + H - 1, 1'b1, "R4");
        expect_at(p + H, 1'b0, "R4");
        tick(H + 5);

        // R9: watchdog disabled, cs idle for a long time.
        p = cyc;
        expect_at(p + 100, 1'b0, "R9");
        tick(102);

        // R5, R8: cs stuck high, two expiries in a row.
        p = cyc; wdog_sel = 2'd0; wdog_en = 1'b1;
        expect_at(p + T0 - 1, 1'b0, "R5");
        expect_at(p + T0, 1'b1, "R5");
        expect_at(p + T0 + H - 1, 1'b1, "R8");
        expect_at(p + T0 + H, 1'b0, "R8");
        expect_at(p + 2 * T0 + H - 1, 1'b0, "R8");
        expect_at(p + 2 * T0 + H, 1'b1, "R8");
        tick(2 * T0 + H + 2);
        wdog_en = 1'b0;
        tick(H + 2);

        // R10: select 2 gives four times the base.
        p = cyc; wdog_sel = 2'd2; wdog_en = 1'b1;
        expect_at(p + 4 * T0 - 1, 1'b0, "R10");
        expect_at(p + 4 * T0, 1'b1, "R10");
        tick(4 * T0 + 2);
        wdog_en = 1'b0;
        tick(H + 2);

        // R7: regular falling edges keep reset released.
        wdog_sel = 2'd0; wdog_en = 1'b1;
        for (int k = 0; k < 10; k++) begin
            expect_at(cyc + 1, 1'b0, "R7");
            cs_n = 1'b0; tick(2);
            cs_n = 1'b1; tick(6);
        end

        // R6: cs stuck low after a final falling edge; fires again after the hold.
        p = cyc; cs_n = 1'b0;
        expect_at(p + S + T0, 1'b0, "R6");
        expect_at(p + S + 1 + T0, 1'b1, "R6");
        expect_at(p + S + 1 + T0 + H, 1'b0, "R8");
        expect_at(p + S + T0 + H + T0, 1'b0, "R6");
        expect_at(p + S + 1 + T0 + H + T0, 1'b1, "R6");
        tick(S + 1 + 2 * T0 + H + 2);
        wdog_en = 1'b0; cs_n = 1'b1;
        tick(H + 2);

        // R3 via pwr_valid, then R2 release once it returns.
        p = cyc;
        expect_at(p + 1, 1'b0, "R3");
        expect_at(p + 2, 1'b1, "R3");
        tick(1); pwr_valid = 1'b0;
        tick(3);
        p = cyc; pwr_valid = 1'b1;
        expect_at(p + H - 1, 1'b1, "R2");
        expect_at(p + H, 1'b0, "R2");
        tick(H + 5);

        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expectations left unchecked, expected 0", q.size());
        end
        finish_run();
    end

endmodule